// File: doc/BRIEF.md
# Block-Paced Receive Buffer with DMA Request

This block holds the data that arrives from a memory card during a block read and hands it to the system in 32-bit words. Card bytes enter through a valid/ready byte stream and are packed into a 256-word buffer. Each block occupies a fixed number of word slots. The drain side presents one word at a time on a shared data output. Either a DMA engine or a CPU takes the word by raising its own ready input.

For each block that is completely present in the buffer, the block raises a single active-low request toward the DMA engine. It drops that request as soon as the first word of the block is taken. No further request appears until every word of the current block has been taken and another whole block is waiting. When the buffer has no slot for the next byte, the block withholds its card clock enable and byte-stream ready, so the buffer never overruns.

Block length is programmed in bytes, from 1 to 1019, so that one block fits the buffer. The block count is programmed from 1 to 255. Both are captured on the transfer start pulse. A start pulse or a soft reset empties the buffer and clears all counters.

Top module: `rx_blk_dma_ctrl`

## Requirements
- R1: After reset, after a soft reset and right after a start pulse, `dma_req_n` is 1 and `rd_valid`, `blk_drained` and `xfer_done` are 0. After reset, `rx_active` and `card_ready` are 0 and `card_clk_en` is 1.
- R2: `dma_req_n` goes low only when every byte of a block of the captured length is in the buffer. If the drain side is idle, it goes low two clock edges after the edge that accepts the block's last byte.
- R3: `dma_req_n` returns to 1 on the edge after the first word of the block is taken, whichever port takes it.
- R4: Only one request is made per block. While a block is being drained, `dma_req_n` stays 1 even if later blocks are complete. The next request comes one edge after the current block's last word is taken.
- R5: Each block is read as exactly floor(length/4)+1 words. Lane k (bits 8k+7:8k) of word n carries byte 4n+k of the block.
- R6: Every lane whose byte index is at or beyond the block length reads as zero. When the length is a multiple of four, this includes a final word that is all zero.
- R7: A word is taken on an edge where `rd_valid` is 1 and either `dma_rd_ready` or `cpu_rd_ready` is 1. Both ports drain the same block count.
- R8: The buffer never holds more than 256 words. When the next byte has no free slot, `card_ready` and `card_clk_en` are 0 while `rx_active` is 1. They return to 1 once a word is taken.
- R9: `rx_active` is 1 from the start pulse until the edge that accepts the last byte of the last block.
- R10: `blk_drained` pulses for one cycle after the edge that takes a block's last word. `xfer_done` pulses in the same cycle for the final block of the programmed count.
- R11: A soft reset in the middle of a transfer discards buffered data and pending requests, ends the transfer, and lets a new transfer run with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of buffer, counters and transfer |
| xfer_start | input | 1 | Start pulse; captures configuration and empties the buffer |
| cfg_blen | input | 11 | Block length in bytes (1..1019) |
| cfg_nblk | input | 8 | Number of blocks in the transfer (1..255) |
| card_valid | input | 1 | Card byte present |
| card_data | input | 8 | Card byte |
| card_ready | output | 1 | Byte accepted on an edge where valid and ready are both 1 |
| card_clk_en | output | 1 | Card clock enable; 0 while stalled on a full buffer |
| rx_active | output | 1 | Card data still expected for this transfer |
| rd_data | output | 32 | Current word, with bytes past the block end zeroed |
| rd_valid | output | 1 | A word of the current block is available |
| dma_rd_ready | input | 1 | DMA takes the word |
| cpu_rd_ready | input | 1 | CPU takes the word |
| dma_req_n | output | 1 | Active-low once-per-block DMA request |
| blk_drained | output | 1 | One-cycle pulse after a block is fully read |
| xfer_done | output | 1 | One-cycle pulse after the last block is fully read |

## Verification
The bench holds a second block in the buffer while the first is only partly drained. A design that re-requested on any buffered block would pull `dma_req_n` low too early. The bench also uses lengths of 1, 6, 8 and 4 bytes. A design that used a ceiling word count would lose the trailing all-zero word, and one without lane masking would return leftover bytes. A 1000-byte, two-block transfer runs with the drain side idle to fill the buffer. It must stall after exactly 1020 accepted bytes, and a design without back-pressure would overwrite unread words. Finally, a soft reset mid-transfer must leave no stale request or stale data for the next transfer.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  // word slots a block occupies: integer part of length/4, plus one
  function automatic logic [15:0] slots_for_len(input logic [15:0] len);
    return (len >> 2) + 16'd1;
  endfunction
endpackage

// File: rtl/rxd_ram.sv
module rxd_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [1:0]    wlane,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [3:0][7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr][wlane] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxd_fill.sv
module rxd_fill #(
  parameter int BLEN_W    = 11,
  parameter int NBLK_W    = 8,
  parameter int BUF_WORDS = 256,
  parameter int AW        = $clog2(BUF_WORDS),
  parameter int WPB_W     = BLEN_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              go,
  input  logic [BLEN_W-1:0] blen,
  input  logic [NBLK_W-1:0] nblk,
  input  logic [WPB_W-1:0]  wpb,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              clk_en,
  input  logic              pop,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output logic [1:0]        wlane,
  output logic [7:0]        wdata,
  output logic              blk_done,
  output logic              active,
  output logic [AW:0]       occ
);
  localparam logic [AW:0] FULL = (AW+1)'(BUF_WORDS);

  logic [BLEN_W-1:0] pos_q;
  logic [AW-1:0]     base_q;
  logic [NBLK_W-1:0] nin_q;
  logic              act_q;
  logic [AW:0]       occ_q;
  logic              last, need, space, acc;

  assign wlane    = pos_q[1:0];
  assign last     = (pos_q == blen - BLEN_W'(1));
  // a byte on lane 0 opens a new slot; a length multiple of 4 also reserves the pad slot
  assign need     = (wlane == 2'd0) || (last && (blen[1:0] == 2'd0));
  assign space    = !need || (occ_q != FULL);
  assign in_ready = act_q && space;
  assign clk_en   = !act_q || space;
  assign acc      = in_valid && in_ready;

  assign we       = acc;
  assign waddr    = base_q + AW'(pos_q >> 2);
  assign wdata    = in_data;
  assign blk_done = acc && last;
  assign active   = act_q;
  assign occ      = occ_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      base_q <= '0;
      nin_q  <= '0;
      act_q  <= 1'b0;
      occ_q  <= '0;
    end else if (clr) begin
      pos_q  <= '0;
      base_q <= '0;
      nin_q  <= '0;
      act_q  <= go;
      occ_q  <= '0;
    end else begin
      if (acc) begin
        if (last) begin
          pos_q  <= '0;
          base_q <= base_q + AW'(wpb);
          nin_q  <= nin_q + NBLK_W'(1);
          if (nin_q + NBLK_W'(1) == nblk) act_q <= 1'b0;
        end else begin
          pos_q <= pos_q + BLEN_W'(1);
        end
      end
      occ_q <= occ_q + (AW+1)'(acc && need) - (AW+1)'(pop);
    end
  end
endmodule

// File: rtl/rxd_drain.sv
module rxd_drain #(
  parameter int BLEN_W = 11,
  parameter int NBLK_W = 8,
  parameter int AW     = 8,
  parameter int WPB_W  = BLEN_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              blk_done,
  input  logic [BLEN_W-1:0] blen,
  input  logic [NBLK_W-1:0] nblk,
  input  logic [WPB_W-1:0]  wpb,
  input  logic [31:0]       mem_rdata,
  output logic [AW-1:0]     raddr,
  input  logic              dma_rdy,
  input  logic              cpu_rdy,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              req_n,
  output logic              pop,
  output logic              drained,
  output logic              done
);
  logic [AW:0]       rdy_q;
  logic              act_q;
  logic [WPB_W-1:0]  wl_q;
  logic [BLEN_W-1:0] bl_q;
  logic [AW-1:0]     rp_q;
  logic [NBLK_W-1:0] nout_q;
  logic              req_q, drained_q, done_q;
  logic              start;

  assign start    = !act_q && (rdy_q != '0);
  assign pop      = act_q && (dma_rdy || cpu_rdy);
  assign rd_valid = act_q;
  assign raddr    = rp_q;
  assign req_n    = req_q;
  assign drained  = drained_q;
  assign done     = done_q;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign rd_data[g*8 +: 8] = (bl_q > BLEN_W'(g)) ? mem_rdata[g*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= '0; act_q <= 1'b0; wl_q <= '0; bl_q <= '0; rp_q <= '0;
      nout_q <= '0; req_q <= 1'b1; drained_q <= 1'b0; done_q <= 1'b0;
    end else if (clr) begin
      rdy_q <= '0; act_q <= 1'b0; wl_q <= '0; bl_q <= '0; rp_q <= '0;
      nout_q <= '0; req_q <= 1'b1; drained_q <= 1'b0; done_q <= 1'b0;
    end else begin
      drained_q <= 1'b0;
      done_q    <= 1'b0;
      rdy_q     <= rdy_q + (AW+1)'(blk_done) - (AW+1)'(start);
      if (start) begin
        act_q <= 1'b1;
        wl_q  <= wpb;
        bl_q  <= blen;
        req_q <= 1'b0;
      end
      if (pop) begin
        req_q <= 1'b1;
        rp_q  <= rp_q + AW'(1);
        wl_q  <= wl_q - WPB_W'(1);
        bl_q  <= (bl_q > BLEN_W'(3)) ? bl_q - BLEN_W'(4) : '0;
        if (wl_q == WPB_W'(1)) begin
          act_q     <= 1'b0;
          drained_q <= 1'b1;
          nout_q    <= nout_q + NBLK_W'(1);
          if (nout_q + NBLK_W'(1) == nblk) done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_blk_dma_ctrl.sv
module rx_blk_dma_ctrl #(
  parameter int BLEN_W    = 11,
  parameter int NBLK_W    = 8,
  parameter int BUF_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              xfer_start,
  input  logic [BLEN_W-1:0] cfg_blen,
  input  logic [NBLK_W-1:0] cfg_nblk,
  input  logic              card_valid,
  input  logic [7:0]        card_data,
  output logic              card_ready,
  output logic              card_clk_en,
  output logic              rx_active,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  input  logic              dma_rd_ready,
  input  logic              cpu_rd_ready,
  output logic              dma_req_n,
  output logic              blk_drained,
  output logic              xfer_done
);
  import rxd_pkg::*;

  localparam int AW    = $clog2(BUF_WORDS);
  localparam int WPB_W = BLEN_W - 1;

  logic [BLEN_W-1:0] blen_q;
  logic [NBLK_W-1:0] nblk_q;
  logic [WPB_W-1:0]  wpb;
  logic              clr, go;
  logic              we, pop, blk_done;
  logic [AW-1:0]     waddr, raddr;
  logic [1:0]        wlane;
  logic [7:0]        wdata;
  logic [31:0]       mem_rdata;
  logic [AW:0]       occ_w;

  assign clr = soft_rst || xfer_start;
  assign go  = xfer_start && !soft_rst;
  assign wpb = WPB_W'(slots_for_len(16'(blen_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen_q <= BLEN_W'(1);
      nblk_q <= NBLK_W'(1);
    end else if (go) begin
      blen_q <= cfg_blen;
      nblk_q <= cfg_nblk;
    end
  end

  rxd_fill #(
    .BLEN_W(BLEN_W), .NBLK_W(NBLK_W), .BUF_WORDS(BUF_WORDS), .AW(AW), .WPB_W(WPB_W)
  ) u_fill (
    .clk(clk), .rst_n(rst_n), .clr(clr), .go(go),
    .blen(blen_q), .nblk(nblk_q), .wpb(wpb),
    .in_valid(card_valid), .in_data(card_data), .in_ready(card_ready),
    .clk_en(card_clk_en), .pop(pop),
    .we(we), .waddr(waddr), .wlane(wlane), .wdata(wdata),
    .blk_done(blk_done), .active(rx_active), .occ(occ_w)
  );

  rxd_ram #(.DEPTH(BUF_WORDS), .AW(AW)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wlane(wlane), .wdata(wdata),
    .raddr(raddr), .rdata(mem_rdata)
  );

  rxd_drain #(
    .BLEN_W(BLEN_W), .NBLK_W(NBLK_W), .AW(AW), .WPB_W(WPB_W)
  ) u_drain (
    .clk(clk), .rst_n(rst_n), .clr(clr), .blk_done(blk_done),
    .blen(blen_q), .nblk(nblk_q), .wpb(wpb),
    .mem_rdata(mem_rdata), .raddr(raddr),
    .dma_rdy(dma_rd_ready), .cpu_rdy(cpu_rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .req_n(dma_req_n),
    .pop(pop), .drained(blk_drained), .done(xfer_done)
  );
endmodule

// File: rtl/rx_blk_dma_ctrl_chk.sv
module rx_blk_dma_ctrl_chk #(
  parameter int BUF_WORDS = 256,
  parameter int AW        = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        card_ready,
  input logic        card_clk_en,
  input logic        rx_active,
  input logic        rd_valid,
  input logic        dma_rd_ready,
  input logic        cpu_rd_ready,
  input logic        dma_req_n,
  input logic        blk_drained,
  input logic        xfer_done,
  input logic [AW:0] occ
);
  p_req_has_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_req_n |-> rd_valid);

  p_req_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_req_n && rd_valid && (dma_rd_ready || cpu_rd_ready)) |=> dma_req_n);

  p_single_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_n && rd_valid) |=> dma_req_n);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (AW+1)'(BUF_WORDS));

  p_stall_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && !card_ready) |-> !card_clk_en);

  p_done_with_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> blk_drained);

  p_drain_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    blk_drained |=> !blk_drained);
endmodule

bind rx_blk_dma_ctrl rx_blk_dma_ctrl_chk #(.BUF_WORDS(BUF_WORDS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .card_ready(card_ready), .card_clk_en(card_clk_en),
  .rx_active(rx_active), .rd_valid(rd_valid), .dma_rd_ready(dma_rd_ready),
  .cpu_rd_ready(cpu_rd_ready), .dma_req_n(dma_req_n), .blk_drained(blk_drained),
  .xfer_done(xfer_done), .occ(occ_w)
);

// File: tb/rx_blk_dma_ctrl_bench.sv
`timescale 1ns/1ps
module rx_blk_dma_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0, xfer_start = 1'b0;
  logic [10:0] cfg_blen = 11'd1;
  logic [7:0]  cfg_nblk = 8'd1;
  logic        card_valid = 1'b0;
  logic [7:0]  card_data = 8'h00;
  logic        card_ready, card_clk_en, rx_active, rd_valid, dma_req_n, blk_drained, xfer_done;
  logic [31:0] rd_data;
  logic        dma_rd_ready = 1'b0, cpu_rd_ready = 1'b0;

  int tests = 0, fails = 0;
  int pops = 0, drains = 0, dones = 0, req_falls = 0, acc_cnt = 0;
  logic prev_req = 1'b1;
  logic [31:0] exp_q [$];

  always #5 clk = ~clk;

  rx_blk_dma_ctrl u_rx_blk_dma_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .xfer_start(xfer_start),
    .cfg_blen(cfg_blen), .cfg_nblk(cfg_nblk), .card_valid(card_valid),
    .card_data(card_data), .card_ready(card_ready), .card_clk_en(card_clk_en),
    .rx_active(rx_active), .rd_data(rd_data), .rd_valid(rd_valid),
    .dma_rd_ready(dma_rd_ready), .cpu_rd_ready(cpu_rd_ready),
    .dma_req_n(dma_req_n), .blk_drained(blk_drained), .xfer_done(xfer_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int s, input int i);
    return 8'(s * 37 + i * 5 + 3);
  endfunction

  task automatic push_block(input int s, input int len);
    for (int w = 0; w <= len / 4; w++) begin
      logic [31:0] word = '0;
      for (int k = 0; k < 4; k++)
        if (w * 4 + k < len) word[k*8 +: 8] = gen(s, w * 4 + k);
      exp_q.push_back(word);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    card_data = b;
    card_valid = 1'b1;
    #1;
    while (!card_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    card_valid = 1'b0;
    acc_cnt++;
  endtask

  task automatic send_block(input int s, input int len);
    push_block(s, len);
    for (int i = 0; i < len; i++) send_byte(gen(s, i));
  endtask

  task automatic start_xfer(input int len, input int nb);
    @(negedge clk);
    cfg_blen = 11'(len);
    cfg_nblk = 8'(nb);
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic wait_sig(input bit want_done);
    int n = 0;
    while (!(want_done ? xfer_done : blk_drained) && n < 3000) begin @(negedge clk); n++; end
  endtask

  // monitor: scoreboard comparison, sampled 1 ns before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (prev_req && !dma_req_n) req_falls++;
      prev_req = dma_req_n;
      if (blk_drained) drains++;
      if (xfer_done) dones++;
      if (rst_n && rd_valid && (dma_rd_ready || cpu_rd_ready)) begin
        pops++;
        if (exp_q.size() == 0) chk("R5 extra word read", rd_data, 32'hx);
        else chk("R5/R6 word data", rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_n after reset", dma_req_n, 1);
    chk("R1 rd_valid after reset", rd_valid, 0);
    chk("R1 rx_active after reset", rx_active, 0);
    chk("R1 card_ready after reset", card_ready, 0);
    chk("R1 card_clk_en after reset", card_clk_en, 1);
    chk("R1 pulses after reset", {blk_drained, xfer_done}, 0);

    // Test A: two 8-byte blocks, request timing and masking
    start_xfer(8, 2);
    chk("R1 req_n after start", dma_req_n, 1);
    chk("R9 rx_active after start", rx_active, 1);
    send_block(1, 8);
    chk("R2 req_n not yet low", dma_req_n, 1);
    @(negedge clk);
    chk("R2 req_n low on complete block", dma_req_n, 0);
    chk("R2 rd_valid with request", rd_valid, 1);
    send_block(2, 8);
    chk("R9 rx_active cleared after last byte", rx_active, 0);
    chk("R4 still one request", dma_req_n, 0);
    dma_rd_ready = 1'b1;
    @(negedge clk);
    dma_rd_ready = 1'b0;
    chk("R3 req_n released after first word", dma_req_n, 1);
    repeat (4) @(negedge clk);
    chk("R4 masked while block open", dma_req_n, 1);
    dma_rd_ready = 1'b1;
    wait_sig(1'b0);
    dma_rd_ready = 1'b0;
    chk("R10 blk_drained pulse", blk_drained, 1);
    chk("R4 req_n high at drain", dma_req_n, 1);
    @(negedge clk);
    chk("R4 next request after drain", dma_req_n, 0);
    cpu_rd_ready = 1'b1;  // R7 CPU port drains second block
    wait_sig(1'b1);
    cpu_rd_ready = 1'b0;
    chk("R10 xfer_done on last block", xfer_done, 1);
    chk("R7 words drained via both ports", pops, 6);

    // Test B: 6-byte blocks, DMA ready held high
    start_xfer(6, 3);
    dma_rd_ready = 1'b1;
    for (int b = 0; b < 3; b++) send_block(10 + b, 6);
    wait_sig(1'b1);
    chk("R10 xfer_done length 6", xfer_done, 1);
    @(negedge clk);
    dma_rd_ready = 1'b0;
    chk("R5 word count length 6", pops, 12);

    // Test C: single byte block
    start_xfer(1, 1);
    cpu_rd_ready = 1'b1;
    send_block(20, 1);
    wait_sig(1'b1);
    @(negedge clk);
    cpu_rd_ready = 1'b0;
    chk("R6 length 1 single word", pops, 13);

    // Test D: fill the buffer with the drain side idle
    start_xfer(1000, 2);
    acc_cnt = 0;
    push_block(30, 1000);
    push_block(31, 1000);
    fork
      begin
        for (int b = 0; b < 2; b++)
          for (int i = 0; i < 1000; i++) send_byte(gen(30 + b, i));
      end
      begin
        repeat (1300) @(negedge clk);
        chk("R8 bytes accepted before stall", acc_cnt, 1020);
        chk("R8 card_ready low when full", card_ready, 0);
        chk("R8 card_clk_en low when full", card_clk_en, 0);
        chk("R8 rx_active while stalled", rx_active, 1);
        dma_rd_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 clock resumes after read", card_clk_en, 1);
      end
    join
    wait_sig(1'b1);
    @(negedge clk);
    dma_rd_ready = 1'b0;
    chk("R5 word count length 1000", pops, 515);

    // Test E: soft reset mid-transfer
    start_xfer(16, 2);
    send_block(40, 16);
    for (int i = 0; i < 5; i++) send_byte(gen(41, i));
    @(negedge clk);
    chk("R11 request pending before soft reset", dma_req_n, 0);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    exp_q.delete();
    chk("R11 req_n after soft reset", dma_req_n, 1);
    chk("R11 rd_valid after soft reset", rd_valid, 0);
    chk("R11 rx_active after soft reset", rx_active, 0);
    chk("R1 card_ready after soft reset", card_ready, 0);
    start_xfer(4, 1);
    dma_rd_ready = 1'b1;
    send_block(50, 4);
    wait_sig(1'b1);
    @(negedge clk);
    dma_rd_ready = 1'b0;
    chk("R6 length 4 pad word count", pops, 517);

    chk("R5 scoreboard empty", exp_q.size(), 0);
    chk("R4 one request per block", req_falls, 10);
    chk("R10 drained pulses", drains, 9);
    chk("R10 done pulses", dones, 5);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule